// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor that finishes one instruction in every clock cycle in which it is allowed to run. In that cycle it fetches a word from its own instruction store and decodes it. It reads two operands from a 32-entry register file and computes in a single shared arithmetic unit. It may read or write its own data store, then writes back a result and picks the next program counter. Eight operations are recognised: add, subtract and signed set-less-than between registers; word load and word store at a register base plus a signed 16-bit displacement; branch when two registers are equal or unequal; and an absolute jump. Every other bit pattern behaves as a no-op that only moves the program counter forward.

Both stores are small internal word arrays that are addressed by byte address. The two low address bits are dropped, and address bits above the array size wrap. While the `run` pin is low, the core is frozen and a valid/ready load port writes words into either store. The load port ignores back-pressure from the source, because `ld_ready` is simply the inverse of `run`. A word moves only in a cycle where `ld_valid` and `ld_ready` are both high at the rising edge. While the core runs, `ld_ready` is low, and any word offered is dropped and not held. The source must keep its word stable until it sees a handshake. Two combinational read-back ports expose one register and one data word, so that results can be inspected.

Top module: `scalar_core`

## Requirements
- R1: After reset, `pc_o` is 0 and every register reads 0; with `run` low, `ld_ready` is 1.
- R2: A word with bits[31:26]=0 and bits[5:0]=0x20 writes rs+rt into rd, where rs=bits[25:21], rt=bits[20:16] and rd=bits[15:11]; the sum wraps modulo 2^32.
- R3: Bits[31:26]=0 with bits[5:0]=0x22 writes rs-rt into rd, wrapping modulo 2^32.
- R4: Bits[31:26]=0 with bits[5:0]=0x2A writes 1 into rd when rs is below rt as signed two's complement numbers, and 0 otherwise, including when the subtraction overflows.
- R5: Opcode 35 loads rt from the data word at byte address rs + sign-extended bits[15:0]; the two low address bits are ignored.
- R6: Opcode 43 stores rt to the data word at byte address rs + sign-extended bits[15:0]; the two low address bits are ignored.
- R7: Opcode 4 sets the next PC to PC+4+(sign-extended bits[15:0] shifted left by 2) when rs equals rt, and to PC+4 otherwise; the offset may be negative.
- R8: Opcode 5 takes the same target when rs differs from rt, and goes to PC+4 otherwise.
- R9: Opcode 2 always sets the next PC to {(PC+4)[31:28], bits[25:0], 2'b00}.
- R10: Register 0 reads as 0 even after an arithmetic or load instruction names it as the destination.
- R11: Any other opcode, and opcode 0 with any other funct value, changes no register and no data word, and advances the PC by 4.
- R12: While `run` is low, the PC and all state hold, and a handshake on the load port writes `ld_data` to the instruction store (`ld_target`=0) or the data store (`ld_target`=1) at byte address `ld_addr`; while `run` is high, `ld_ready` is 0 and offered words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of PC and registers |
| run | input | 1 | High: execute one instruction per cycle; low: freeze |
| ld_valid | input | 1 | Load port word offered |
| ld_ready | output | 1 | Load port can accept (equals not `run`) |
| ld_target | input | 1 | 0 = instruction store, 1 = data store |
| ld_addr | input | 32 | Byte address of the loaded word |
| ld_data | input | 32 | Word to load |
| pc_o | output | 32 | Current program counter |
| dbg_reg_sel | input | 5 | Register to read back |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_addr | input | 32 | Byte address of data word to read back |
| dbg_mem_val | output | 32 | Value of the selected data word |

## Verification
The bench builds the core with its default sizes of 64 instruction words and 64 data words. These sizes are large enough for each directed program and its data, and small enough that a displacement can land a store on word 0. A negative displacement and a misaligned byte address both hit the dropped low bits. Backward branches are exercised by a self-loop near the top of the program. The signed-overflow edge of set-less-than is exercised by adding the largest positive value to one.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RSELW = $clog2(NREG);

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JMP   = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_BNE   = 6'd5;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SLT = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    dst_rd;
    logic    mem_rd;
    logic    mem_wr;
    logic    use_imm;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        if (funct == FN_ADD) begin
          ctrl.reg_wr = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctrl.reg_wr = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end else if (funct == FN_SLT) begin
          ctrl.reg_wr = 1'b1;
          ctrl.alu_op = ALU_SLT;
        end
      end
      OPC_LOAD: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.mem_rd  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_wr  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.br_eq  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_BNE: begin
        ctrl.br_ne  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_JMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

  // R11
  excl_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.reg_wr, ctrl.mem_wr, ctrl.br_eq | ctrl.br_ne, ctrl.jump}));

  // R5
  load_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_rd |-> (ctrl.reg_wr && ctrl.use_imm && !ctrl.dst_rd));
endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;
  logic            ovf;
  logic            less;

  always_comb begin
    sum  = a + b;
    diff = a - b;
    ovf  = (a[XLEN-1] != b[XLEN-1]) && (diff[XLEN-1] != a[XLEN-1]);
    less = diff[XLEN-1] ^ ovf;
    zero = (diff == '0);
    unique case (op)
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, less};
      default: y = sum;
    endcase
  end

  // R4
  slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ALU_SLT) |-> (y[XLEN-1:1] == '0));

  // R7
  zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> (a == b));
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RSELW-1:0] waddr,
  input  logic [XLEN-1:0]  wdata,
  input  logic [RSELW-1:0] raddr_a,
  output logic [XLEN-1:0]  rdata_a,
  input  logic [RSELW-1:0] raddr_b,
  output logic [XLEN-1:0]  rdata_b,
  input  logic [RSELW-1:0] raddr_c,
  output logic [XLEN-1:0]  rdata_c
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_c = regs[raddr_c];

  // R10
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);

  // R2
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/scp_wordmem.sv
module scp_wordmem
  import scp_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [IDXW-1:0] raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [IDXW-1:0] raddr_b,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R6
  store_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/scalar_core.sv
module scalar_core
  import scp_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        ld_valid,
  output logic        ld_ready,
  input  logic        ld_target,
  input  logic [31:0] ld_addr,
  input  logic [31:0] ld_data,
  output logic [31:0] pc_o,
  input  logic [4:0]  dbg_reg_sel,
  output logic [31:0] dbg_reg_val,
  input  logic [31:0] dbg_mem_addr,
  output logic [31:0] dbg_mem_val
);
  localparam int IW = $clog2(IMEM_WORDS);
  localparam int DW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, jmp_target;
  logic [XLEN-1:0] instr;
  logic [5:0]      f_op, f_fn;
  logic [4:0]      f_rs, f_rt, f_rd, f_sh;
  logic [15:0]     f_imm;
  logic [25:0]     f_tgt;
  logic [XLEN-1:0] imm_sx;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dmem_rdata, wb_data;
  logic            alu_zero, take_br;
  logic [4:0]      wb_sel;
  logic            ld_fire;
  logic            dmem_we;
  logic [DW-1:0]   dmem_widx;
  logic [XLEN-1:0] dmem_wdata;
  logic            unused_bits;

  assign ld_ready = ~run;
  assign ld_fire  = ld_valid & ld_ready;
  assign pc_o     = pc_q;

  // instruction fields
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign f_tgt = instr[25:0];
  assign imm_sx = {{(XLEN-16){f_imm[15]}}, f_imm};

  scp_wordmem #(.WORDS(IMEM_WORDS)) u_imem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ld_fire & ~ld_target),
    .waddr   (ld_addr[IW+1:2]),
    .wdata   (ld_data),
    .raddr_a (pc_q[IW+1:2]),
    .rdata_a (instr),
    .raddr_b (pc_q[IW+1:2]),
    .rdata_b ()
  );

  scp_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  assign wb_sel  = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_data = ctrl.mem_rd ? dmem_rdata : alu_y;

  scp_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (run & ctrl.reg_wr),
    .waddr   (wb_sel),
    .wdata   (wb_data),
    .raddr_a (f_rs),
    .rdata_a (rs_val),
    .raddr_b (f_rt),
    .rdata_b (rt_val),
    .raddr_c (dbg_reg_sel),
    .rdata_c (dbg_reg_val)
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

  scp_alu u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  // data store write port is shared: core when running, loader when frozen
  always_comb begin
    if (run) begin
      dmem_we    = ctrl.mem_wr;
      dmem_widx  = alu_y[DW+1:2];
      dmem_wdata = rt_val;
    end else begin
      dmem_we    = ld_fire & ld_target;
      dmem_widx  = ld_addr[DW+1:2];
      dmem_wdata = ld_data;
    end
  end

  scp_wordmem #(.WORDS(DMEM_WORDS)) u_dmem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (dmem_we),
    .waddr   (dmem_widx),
    .wdata   (dmem_wdata),
    .raddr_a (alu_y[DW+1:2]),
    .rdata_a (dmem_rdata),
    .raddr_b (dbg_mem_addr[DW+1:2]),
    .rdata_b (dbg_mem_val)
  );

  // next program counter
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], f_tgt, 2'b00};
  assign take_br    = (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);

  always_comb begin
    if (ctrl.jump)    pc_next = jmp_target;
    else if (take_br) pc_next = br_target;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_next;
  end

  assign unused_bits = ^{f_sh, ld_addr[31:IW+2], ld_addr[1:0],
                         dbg_mem_addr[31:DW+2], dbg_mem_addr[1:0],
                         alu_y[31:DW+2], alu_y[1:0], pc_q[31:IW+2],
                         pc_q[1:0], imm_sx[31:30]};

  // R12
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc_q));

  // R11
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !take_br && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

  // R9
  pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl.jump) |=> (pc_q[27:0] == {$past(f_tgt), 2'b00}));

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  // R12
  ld_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !ld_fire);
endmodule

// File: tb/tb_scalar_core.sv
module tb_scalar_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_target = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val;
  logic [31:0] dbg_mem_addr = '0;
  logic [31:0] dbg_mem_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scalar_core dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_target(ld_target),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_val(dbg_mem_val)
  );

  function automatic logic [31:0] r_ins(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] j_ins(logic [25:0] t);
    return {6'd2, t};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; ld_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_word(logic tgt, int idx, logic [31:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_target = tgt; ld_addr = idx * 4; ld_data = w;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_cycles(int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    run = 1'b0;
  endtask

  task automatic reg_is(string req, int r, logic [31:0] exp);
    dbg_reg_sel = r[4:0];
    #1;
    chk(req, dbg_reg_val, exp);
  endtask

  task automatic mem_is(string req, logic [31:0] a, logic [31:0] exp);
    dbg_mem_addr = a;
    #1;
    chk(req, dbg_mem_val, exp);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 pc", pc_o, 32'd0);
    chk("R1 ready", {31'd0, ld_ready}, 32'd1);
    reg_is("R1 r5", 5, 32'd0);
    reg_is("R1 r31", 31, 32'd0);
  endtask

  task automatic t_arith();
    do_reset();
    load_word(1, 0, 32'd7);
    load_word(1, 1, 32'hFFFF_FFFD);
    load_word(1, 2, 32'h7FFF_FFFF);
    load_word(1, 3, 32'd1);
    load_word(0, 0, i_ins(6'd35, 0, 1, 16'd0));
    load_word(0, 1, i_ins(6'd35, 0, 2, 16'd4));
    load_word(0, 2, i_ins(6'd35, 0, 3, 16'd8));
    load_word(0, 3, i_ins(6'd35, 0, 4, 16'd12));
    load_word(0, 4, r_ins(1, 2, 5, 6'h20));
    load_word(0, 5, r_ins(1, 2, 6, 6'h22));
    load_word(0, 6, r_ins(3, 4, 7, 6'h20));
    load_word(0, 7, r_ins(2, 1, 8, 6'h2A));
    load_word(0, 8, r_ins(1, 2, 9, 6'h2A));
    load_word(0, 9, r_ins(2, 1, 10, 6'h22));
    load_word(0, 10, r_ins(7, 3, 11, 6'h2A));
    run_cycles(11);
    chk("R11 pc after 11", pc_o, 32'd44);
    reg_is("R2 add", 5, 32'd4);
    reg_is("R3 sub", 6, 32'd10);
    reg_is("R2 wrap", 7, 32'h8000_0000);
    reg_is("R4 neg<pos", 8, 32'd1);
    reg_is("R4 pos<neg", 9, 32'd0);
    reg_is("R3 neg result", 10, 32'hFFFF_FFF6);
    reg_is("R4 overflow", 11, 32'd1);
  endtask

  task automatic t_memory();
    do_reset();
    load_word(1, 0, 32'd0);
    load_word(1, 4, 32'd20);
    load_word(1, 5, 32'hABCD_1234);
    load_word(1, 7, 32'd0);
    load_word(0, 0, i_ins(6'd35, 0, 1, 16'd16));
    load_word(0, 1, i_ins(6'd35, 1, 2, 16'd0));
    load_word(0, 2, i_ins(6'd35, 1, 3, 16'hFFFC));
    load_word(0, 3, i_ins(6'd43, 1, 2, 16'd8));
    load_word(0, 4, i_ins(6'd43, 1, 3, 16'hFFEE));
    load_word(0, 5, i_ins(6'd35, 1, 4, 16'd1));
    run_cycles(6);
    reg_is("R5 base load", 1, 32'd20);
    reg_is("R5 reg base", 2, 32'hABCD_1234);
    reg_is("R5 negative offset", 3, 32'd20);
    reg_is("R5 misaligned", 4, 32'hABCD_1234);
    mem_is("R6 store", 32'd28, 32'hABCD_1234);
    mem_is("R6 misaligned neg store", 32'd0, 32'd20);
  endtask

  task automatic t_branch();
    do_reset();
    load_word(1, 0, 32'd5);
    load_word(1, 1, 32'd5);
    load_word(1, 2, 32'd9);
    load_word(0, 0, i_ins(6'd35, 0, 1, 16'd0));
    load_word(0, 1, i_ins(6'd35, 0, 2, 16'd4));
    load_word(0, 2, i_ins(6'd35, 0, 3, 16'd8));
    load_word(0, 3, i_ins(6'd4, 1, 2, 16'd2));
    load_word(0, 4, r_ins(1, 1, 10, 6'h20));
    load_word(0, 5, r_ins(1, 1, 10, 6'h20));
    load_word(0, 6, i_ins(6'd5, 1, 3, 16'd1));
    load_word(0, 7, r_ins(1, 1, 11, 6'h20));
    load_word(0, 8, i_ins(6'd4, 1, 3, 16'd1));
    load_word(0, 9, r_ins(1, 3, 12, 6'h20));
    load_word(0, 10, i_ins(6'd5, 1, 2, 16'd1));
    load_word(0, 11, r_ins(1, 2, 13, 6'h20));
    load_word(0, 12, j_ins(26'd15));
    load_word(0, 13, r_ins(1, 1, 14, 6'h20));
    load_word(0, 14, r_ins(1, 1, 14, 6'h20));
    load_word(0, 15, r_ins(3, 3, 15, 6'h20));
    load_word(0, 16, i_ins(6'd4, 0, 0, 16'hFFFF));
    run_cycles(15);
    chk("R7 backward self loop", pc_o, 32'd64);
    reg_is("R7 beq taken skips", 10, 32'd0);
    reg_is("R8 bne taken skips", 11, 32'd0);
    reg_is("R7 beq falls through", 12, 32'd14);
    reg_is("R8 bne falls through", 13, 32'd10);
    reg_is("R9 jump skips", 14, 32'd0);
    reg_is("R9 jump target", 15, 32'd18);
  endtask

  task automatic t_zero_and_unknown();
    do_reset();
    load_word(1, 0, 32'h55);
    load_word(1, 2, 32'h77);
    load_word(0, 0, i_ins(6'd35, 0, 1, 16'd0));
    load_word(0, 1, i_ins(6'd35, 0, 0, 16'd0));
    load_word(0, 2, r_ins(1, 1, 0, 6'h20));
    load_word(0, 3, i_ins(6'h3F, 1, 5, 16'h0001));
    load_word(0, 4, r_ins(1, 1, 6, 6'h21));
    load_word(0, 5, i_ins(6'd41, 0, 1, 16'd8));
    load_word(0, 6, r_ins(0, 1, 7, 6'h20));
    run_cycles(7);
    chk("R11 pc past no-ops", pc_o, 32'd28);
    reg_is("R10 r0 after writes", 0, 32'd0);
    reg_is("R10 r0 read as operand", 7, 32'h55);
    reg_is("R11 unknown op no write", 5, 32'd0);
    reg_is("R11 unknown funct no write", 6, 32'd0);
    mem_is("R11 unknown op no store", 32'd8, 32'h77);
  endtask

  task automatic t_hold_and_port();
    do_reset();
    load_word(1, 10, 32'h1111);
    load_word(0, 0, r_ins(0, 0, 1, 6'h20));
    load_word(0, 1, r_ins(0, 0, 1, 6'h20));
    load_word(0, 2, r_ins(0, 0, 1, 6'h20));
    load_word(0, 3, i_ins(6'd4, 0, 0, 16'hFFFF));
    run_cycles(2);
    chk("R12 pc after 2", pc_o, 32'd8);
    repeat (5) @(negedge clk);
    chk("R12 pc held", pc_o, 32'd8);
    run_cycles(1);
    chk("R12 pc resumes", pc_o, 32'd12);
    @(negedge clk);
    run = 1'b1;
    ld_valid = 1'b1; ld_target = 1'b1; ld_addr = 32'd40; ld_data = 32'hDEAD;
    #1;
    chk("R12 ready low while running", {31'd0, ld_ready}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    ld_target = 1'b0; ld_addr = 32'd12; ld_data = 32'hFFFF_FFFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    run = 1'b0; ld_valid = 1'b0;
    mem_is("R12 data load ignored", 32'd40, 32'h1111);
    chk("R12 loop intact", pc_o, 32'd12);
    run_cycles(3);
    chk("R12 instr load ignored", pc_o, 32'd12);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arith();
    t_memory();
    t_branch();
    t_zero_and_unknown();
    t_hold_and_port();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule